// File: doc/BRIEF.md
# GF(2) Modular Multiplier with Loadable Reduction Matrix

This block multiplies two residues modulo a generator polynomial that is chosen at run time. Each operation presents two W-bit operands and a degree n (1 to W). The operands are polynomials over GF(2) of degree below n. The result is their product reduced modulo the generator, n bits wide in a W-bit field.

The multiply itself is carry-less and the same for every generator. The generator enters only through a reduction matrix supplied on an input port. Row i of that matrix holds the residue of x^(n+i) modulo the generator. After the multiply, every product bit at position n or above selects its row, and the selected rows are XORed together. The product bits below n are already reduced, so they skip the matrix and are XORed straight onto that sum. A single datapath therefore serves any generator up to degree W.

The multiply and the reduction sit in two register stages. A new operation can be issued on every clock, and its result appears a fixed two cycles later. Whoever drives the block computes the matrix contents and holds the matrix port steady while operations that use it are in flight.

Top module: `gfmm_modmul`

## Requirements
- R1: `out_valid` is high exactly two rising clock edges after an edge at which `in_valid` was sampled high. Back-to-back operations are accepted on every cycle with no stall.
- R2: When the matrix matches generator p of degree n, `result` equals (op_a · op_b) mod p. The product is the carry-less GF(2) product. Operands are residues, meaning their bits at position n and above are zero.
- R3: When the carry-less product has no set bit at position n or above, `result` equals that product, whatever the matrix holds.
- R4: Matrix row i occupies bits [i·W +: W] of `red_matrix`, for i = 0 to W-2. A set product bit at position n+i XORs row i into the result.
- R5: For n < W, result bits n and above are zero, even when matrix rows carry ones in those positions.
- R6: If either operand is zero, the result is zero.
- R7: While `out_valid` is low, `result` is zero.
- R8: During and right after reset, `out_valid` and `result` are zero.
- R9: The degree is sampled together with the operands. Consecutive operations may each use a different degree.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Issues an operation this cycle |
| op_a | input | W | First operand residue |
| op_b | input | W | Second operand residue |
| degree | input | $clog2(W+1) | Generator degree n, 1 to W |
| red_matrix | input | (W-1)·W | Reduction rows; row i is x^(n+i) mod p |
| out_valid | output | 1 | Result valid, two cycles after issue |
| result | output | W | Reduced product, zero above bit n-1 |

## Verification
The assertions assume several things about each issued operation. Its degree lies between 1 and W. Both operands are true residues with no bits at position n or above. The matrix does not change while an operation sits between the two stages. The property that a unit second operand returns the first operand relies on the residue condition. The stimulus masks every operand to its degree and draws degrees only from 1 to W. It changes the matrix only after two idle cycles have drained the pipeline.

// File: rtl/gfmm_pkg.sv
package gfmm_pkg;

    // Mask with the n lowest bits set, wide enough for any supported word.
    function automatic logic [63:0] low_mask(input int n);
        if (n >= 64)
            return '1;
        else
            return (64'd1 << n) - 64'd1;
    endfunction

endpackage

// File: rtl/gfmm_clmul.sv
// Carry-less (GF(2)) multiply of two W-bit polynomials.
module gfmm_clmul #(
    parameter int W = 32
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-2:0] p
);
    localparam int PW = 2 * W - 1;

    logic [PW-1:0] part [W];

    for (genvar i = 0; i < W; i++) begin : g_part
        assign part[i] = b[i] ? (PW'(a) << i) : '0;
    end

    always_comb begin
        p = '0;
        for (int i = 0; i < W; i++)
            p ^= part[i];
    end
endmodule

// File: rtl/gfmm_reducer.sv
// GF(2) matrix-vector product: XOR of the rows selected by the high bits.
module gfmm_reducer #(
    parameter int W = 32
) (
    input  logic [W-2:0]       hi,
    input  logic [(W-1)*W-1:0] matrix,
    output logic [W-1:0]       fold
);
    localparam int NR = W - 1;

    logic [W-1:0] term [NR];

    for (genvar i = 0; i < NR; i++) begin : g_row
        assign term[i] = hi[i] ? matrix[i*W +: W] : '0;
    end

    always_comb begin
        fold = '0;
        for (int i = 0; i < NR; i++)
            fold ^= term[i];
    end
endmodule

// File: rtl/gfmm_modmul.sv
// Two-stage modular multiplier: stage 1 holds the raw product,
// stage 2 holds the reduced and masked result.
module gfmm_modmul #(
    parameter int W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [W-1:0]               op_a,
    input  logic [W-1:0]               op_b,
    input  logic [$clog2(W+1)-1:0]     degree,
    input  logic [(W-1)*W-1:0]         red_matrix,
    output logic                       out_valid,
    output logic [W-1:0]               result
);
    localparam int PW = 2 * W - 1;
    localparam int NR = W - 1;
    localparam int DW = $clog2(W + 1);

    typedef struct packed {
        logic          s1_vld;
        logic [PW-1:0] s1_prod;
        logic [DW-1:0] s1_deg;
        logic          s2_vld;
        logic [W-1:0]  s2_res;
    } pipe_t;

    pipe_t         cur_q, nxt_d;
    logic [PW-1:0] prod_w;
    logic [NR-1:0] hi_w;
    logic [W-1:0]  fold_w;
    logic [W-1:0]  mask_w;

    gfmm_clmul #(.W(W)) u_clmul (
        .a (op_a),
        .b (op_b),
        .p (prod_w)
    );

    // Bits n .. n+W-2 of the registered product select matrix rows.
    assign hi_w   = NR'(cur_q.s1_prod >> cur_q.s1_deg);
    assign mask_w = W'(gfmm_pkg::low_mask(int'(cur_q.s1_deg)));

    gfmm_reducer #(.W(W)) u_reducer (
        .hi     (hi_w),
        .matrix (red_matrix),
        .fold   (fold_w)
    );

    always_comb begin
        nxt_d         = cur_q;
        nxt_d.s1_vld  = in_valid;
        nxt_d.s1_prod = in_valid ? prod_w : '0;
        nxt_d.s1_deg  = in_valid ? degree : '0;
        nxt_d.s2_vld  = cur_q.s1_vld;
        nxt_d.s2_res  = cur_q.s1_vld ? ((cur_q.s1_prod[W-1:0] ^ fold_w) & mask_w) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_q <= '0;
        else
            cur_q <= nxt_d;
    end

    assign out_valid = cur_q.s2_vld;
    assign result    = cur_q.s2_res;
endmodule

// File: rtl/gfmm_checks.sv
module gfmm_checks #(
    parameter int W = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic [W-1:0]           op_a,
    input logic [W-1:0]           op_b,
    input logic [$clog2(W+1)-1:0] degree,
    input logic                   out_valid,
    input logic [W-1:0]           result
);
    assert_operand_residue_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (degree >= 1 && int'(degree) <= W &&
                      (op_a & ~W'(gfmm_pkg::low_mask(int'(degree)))) == '0 &&
                      (op_b & ~W'(gfmm_pkg::low_mask(int'(degree)))) == '0));

    assert_issue_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);

    assert_valid_origin_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));

    assert_unit_operand_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_b == W'(1)) |=> ##1 (result == $past(op_a, 2)));

    assert_high_bits_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (result & ~W'(gfmm_pkg::low_mask(int'($past(degree, 2))))) == '0);

    assert_zero_operand_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_a == '0 || op_b == '0)) |=> ##1 (result == '0));

    assert_idle_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> result == '0);
endmodule

bind gfmm_modmul gfmm_checks #(.W(W)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .degree    (degree),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/tb_gfmm_modmul.sv
`timescale 1ns/1ps
module tb_gfmm_modmul;
    localparam int W  = 8;
    localparam int NR = W - 1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic [W-1:0]         op_a = '0;
    logic [W-1:0]         op_b = '0;
    logic [3:0]           degree = 4'd1;
    logic [NR*W-1:0]      red_matrix = '0;
    logic                 out_valid;
    logic [W-1:0]         result;

    int n_run = 0;
    int n_bad = 0;
    bit finished = 0;

    logic         pv [2];
    logic [W-1:0] pe [2];
    string        pt [2];

    always #4 clk = ~clk;

    gfmm_modmul #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .degree(degree), .red_matrix(red_matrix), .out_valid(out_valid), .result(result)
    );

    function automatic logic [15:0] cl_mul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] r = '0;
        for (int i = 0; i < 8; i++)
            if (b[i]) r ^= 16'(a) << i;
        return r;
    endfunction

    function automatic logic [7:0] mk(input int n);
        return (n >= 8) ? 8'hFF : 8'((16'd1 << n) - 16'd1);
    endfunction

    // Reference: long division by p = x^n + plow.
    function automatic logic [7:0] ref_mod(input logic [7:0] a, input logic [7:0] b,
                                           input int n, input logic [7:0] plow);
        logic [15:0] r = cl_mul(a, b);
        for (int k = 14; k >= n; k--)
            if (r[k]) r ^= (16'd1 << k) ^ (16'(plow) << (k - n));
        return r[7:0] & mk(n);
    endfunction

    // Matrix rows x^(n+i) mod p.
    function automatic logic [NR*W-1:0] build_rows(input int n, input logic [7:0] plow);
        logic [NR*W-1:0] m = '0;
        logic [15:0] r = 16'(plow);
        for (int i = 0; i < NR; i++) begin
            m[i*W +: W] = r[7:0];
            r = r << 1;
            if (r[n]) r ^= (16'd1 << n) | 16'(plow);
        end
        return m;
    endfunction

    // Row-selection model used with arbitrary matrix contents.
    function automatic logic [7:0] row_model(input logic [7:0] a, input logic [7:0] b,
                                             input int n, input logic [NR*W-1:0] m);
        logic [15:0] pr = cl_mul(a, b);
        logic [7:0]  r  = pr[7:0];
        for (int i = 0; i < NR; i++)
            if (n + i <= 14 && pr[n+i]) r ^= m[i*W +: W];
        return r & mk(n);
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cycle(input logic v, input logic [7:0] a, input logic [7:0] b,
                         input int n, input logic [7:0] e, input string tg);
        @(negedge clk);
        check("R1", W'(out_valid), W'(pv[1]));
        if (pv[1]) check(pt[1], result, pe[1]);
        else       check("R7", result, '0);
        pv[1] = pv[0]; pe[1] = pe[0]; pt[1] = pt[0];
        pv[0] = v;     pe[0] = e;     pt[0] = tg;
        in_valid = v;
        op_a     = v ? a : '0;
        op_b     = v ? b : '0;
        degree   = 4'(n);
    endtask

    task automatic flush();
        cycle(0, 0, 0, 1, 0, "R7");
        cycle(0, 0, 0, 1, 0, "R7");
    endtask

    function automatic logic [7:0] plow_of(input int n, input int k);
        logic [7:0] t0 [9] = '{8'h0, 8'h1, 8'h3, 8'h3, 8'h3, 8'h5, 8'h3, 8'h3, 8'h1D};
        if (k == 0) return t0[n];
        return 8'((n * 37) | 1) & mk(n);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

    initial begin
        pv[0] = 0; pv[1] = 0; pe[0] = '0; pe[1] = '0; pt[0] = ""; pt[1] = "";
        repeat (3) @(negedge clk);
        check("R8", W'(out_valid), '0);
        check("R8", result, '0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R8", W'(out_valid), '0);
        check("R8", result, '0);

        // R2: exhaustive over residues for each degree with real generators.
        for (int n = 1; n <= W; n++) begin
            for (int k = 0; k < ((n <= 6) ? 2 : 1); k++) begin
                logic [7:0] pl = plow_of(n, k);
                flush();
                red_matrix = build_rows(n, pl);
                for (int a = 0; a < (1 << n); a++)
                    for (int b = 0; b < (1 << n); b++)
                        cycle(1, 8'(a), 8'(b), n, ref_mod(8'(a), 8'(b), n, pl),
                              (a == 0 || b == 0) ? "R6" : "R2");
            end
        end
        flush();

        // R4: single high bit n+i selects row i of an arbitrary matrix.
        red_matrix = {$urandom, $urandom};
        for (int n = 5; n <= W; n += 3)
            for (int i = 0; i <= n - 2; i++)
                cycle(1, 8'(1 << (n - 1)), 8'(1 << (i + 1)), n,
                      red_matrix[i*W +: W] & mk(n), "R4");
        flush();

        // R3/R5/R9: random degree per cycle, bubbles, arbitrary matrix.
        for (int j = 0; j < 3000; j++) begin
            int          n = 1 + int'($urandom % W);
            logic [7:0]  a = 8'($urandom) & mk(n);
            logic [7:0]  b = 8'($urandom) & mk(n);
            logic        v = ($urandom % 4) != 0;
            logic [15:0] pr = cl_mul(a, b);
            string       tg = ((pr >> n) == 0) ? "R3" : (n < W) ? "R5" : "R9";
            cycle(v, a, b, n, row_model(a, b, n, red_matrix), tg);
        end
        flush();

        // R6: zero operand against an arbitrary matrix.
        cycle(1, 8'h00, 8'hB7, 8, 8'h00, "R6");
        cycle(1, 8'h5A, 8'h00, 8, 8'h00, "R6");
        flush();

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule